// File: doc/BRIEF.md
# Serial-Triggered Converter Sampler

This block is a small serial peripheral that sleeps until a host sends it any byte over an asynchronous 8N1 link (9600 bit/s in both directions by default). The byte's arrival starts one conversion on an attached parallel-output analog-to-digital converter. When the converter signals that it has finished, the block sends its 8-bit result back to the host as a single 8N1 frame.

Inside are a baud-tick divider, a 16x oversampling receiver, a transmitter and a small handshake controller. The controller keeps a "byte received" flag. That flag drives the converter's active-low start/reset input directly, so the converter is held in reset while the flag is low, and the flag's rising edge starts a conversion. A synchronised falling edge on the converter's active-low completion input loads the result into the transmitter and clears the flag. This re-arms the block. The content of the trigger byte is never used.

Top module: `adc_uart_bridge`

## Requirements
- R1: Out of reset, `txd` is high, `adc_start_n` is low (converter held in reset) and `frame_err` is low.
- R2: A complete 8N1 frame whose stop bit samples high drives `adc_start_n` high by the end of that stop bit. `adc_start_n` never rises without a received byte.
- R3: A low pulse on `rxd` shorter than half a bit period is rejected as a start bit and starts no conversion.
- R4: A frame whose stop bit samples low raises `frame_err` for exactly one clock cycle and leaves `adc_start_n` low.
- R5: While a conversion is running, a falling edge on `adc_eoc_n` (taken through a two-flop synchroniser) drives `adc_start_n` low and starts a reply. Until that edge, `adc_start_n` stays high.
- R6: The reply frame sends `adc_data` as sampled at the completion edge. The frame is a low start bit, then the eight data bits least significant first, then a high stop bit. Each bit lasts 16 oversampling ticks. `txd` is high whenever no reply is being sent.
- R7: A trigger byte that arrives while a conversion is running, or while a reply is being sent, is ignored. At most one request is outstanding, so `adc_start_n` is never high while a reply is in flight.
- R8: A falling edge on `adc_eoc_n` while no conversion is running produces no reply.
- R9: Any byte value works as a trigger.
- R10: Only the falling edge of `adc_eoc_n` counts. If the line is already low when a conversion starts, the conversion stays pending until the line rises and falls again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line from host (asynchronous) |
| txd | output | 1 | Serial transmit line to host, idles high |
| adc_start_n | output | 1 | Converter start/reset; low holds reset, rising edge starts |
| adc_eoc_n | input | 1 | Converter end-of-conversion, active low (asynchronous) |
| adc_data | input | 8 | Converter result bus |
| frame_err | output | 1 | One-cycle pulse on a frame with a low stop bit |

## Verification
The bench builds the block with `CLK_HZ` = 307200 and `BAUD` = 9600, so one oversampling tick is two clock cycles and a whole frame is about 320 cycles. This keeps each trigger-convert-reply round trip short. It lets the bench sweep forty trigger and result values, including every walking-one and walking-zero pattern. It also leaves room for directed runs of glitch rejection, a bad stop bit, a stray completion edge, a completion line already held low, and triggers that arrive during a conversion and during a reply.

// File: rtl/adcb_pkg.sv
package adcb_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/adcb_tick.sv
module adcb_tick #(
    parameter int DIV = 325
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/adcb_rx.sv
module adcb_rx
    import adcb_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rxd,
    output logic valid_o,
    output logic ferr_o
);
    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW) + 1;
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
    localparam logic [IW-1:0] TOPB = IW'(DW - 1);

    typedef struct packed {
        rx_state_e     state;
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic          valid;
        logic          ferr;
    } rx_regs_t;

    rx_regs_t d, q;

    always_comb begin
        d       = q;
        d.s1    = rxd;
        d.s2    = q.s1;
        d.valid = 1'b0;
        d.ferr  = 1'b0;
        case (q.state)
            RX_IDLE: begin
                if (!q.s2) begin
                    d.state = RX_START;
                    d.cnt   = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q.cnt == HALF) begin
                        d.cnt   = '0;
                        d.idx   = '0;
                        d.state = q.s2 ? RX_IDLE : RX_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (q.cnt == LAST) begin
                        d.cnt = '0;
                        if (q.idx == TOPB) d.state = RX_STOP;
                        else               d.idx   = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (q.cnt == LAST) begin
                        d.valid = q.s2;
                        d.ferr  = !q.s2;
                        d.state = RX_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= RX_IDLE;
            q.s1    <= 1'b1;
            q.s2    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign valid_o = q.valid;
    assign ferr_o  = q.ferr;
endmodule

// File: rtl/adcb_tx.sv
module adcb_tx #(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] data,
    output logic          txd_o,
    output logic          busy_o
);
    localparam int FW = DW + 2;
    localparam int CW = $clog2(OVS);
    localparam int LW = $clog2(FW);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    typedef struct packed {
        logic [FW-1:0] shift;
        logic [CW-1:0] cnt;
        logic [LW-1:0] left;
        logic          busy;
    } tx_regs_t;

    tx_regs_t d, q;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (load) begin
                d.shift = {1'b1, data, 1'b0};
                d.cnt   = '0;
                d.left  = LW'(FW - 1);
                d.busy  = 1'b1;
            end
        end else if (tick) begin
            if (q.cnt == LAST) begin
                d.cnt = '0;
                if (q.left == '0) begin
                    d.busy  = 1'b0;
                    d.shift = '1;
                end else begin
                    d.shift = {1'b1, q.shift[FW-1:1]};
                    d.left  = q.left - 1'b1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.shift <= '1;
        end else begin
            q <= d;
        end
    end

    assign txd_o  = q.shift[0];
    assign busy_o = q.busy;
endmodule

// File: rtl/adc_uart_bridge.sv
module adc_uart_bridge #(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 9600,
    parameter int OVS    = 16,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd,
    output logic          txd,
    output logic          adc_start_n,
    input  logic          adc_eoc_n,
    input  logic [DW-1:0] adc_data,
    output logic          frame_err
);
    localparam int DIV = CLK_HZ / (BAUD * OVS);

    typedef struct packed {
        logic flag;
        logic e1;
        logic e2;
        logic e3;
    } ctl_regs_t;

    ctl_regs_t d, q;
    logic tick, rx_valid, tx_busy, eoc_fall, tx_load;

    adcb_tick #(.DIV(DIV)) i_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    adcb_rx #(.OVS(OVS), .DW(DW)) i_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .valid_o(rx_valid), .ferr_o(frame_err)
    );

    adcb_tx #(.OVS(OVS), .DW(DW)) i_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(tx_load),
        .data(adc_data), .txd_o(txd), .busy_o(tx_busy)
    );

    assign eoc_fall = q.e3 && !q.e2;
    assign tx_load  = q.flag && eoc_fall;

    always_comb begin
        d    = q;
        d.e1 = adc_eoc_n;
        d.e2 = q.e1;
        d.e3 = q.e2;
        if (tx_load)
            d.flag = 1'b0;
        else if (rx_valid && !q.flag && !tx_busy)
            d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{flag: 1'b0, e1: 1'b1, e2: 1'b1, e3: 1'b1};
        else        q <= d;
    end

    assign adc_start_n = q.flag;
endmodule

// File: rtl/adcb_chk.sv
module adcb_chk (
    input logic clk,
    input logic rst_n,
    input logic txd,
    input logic adc_start_n,
    input logic frame_err,
    input logic rx_valid,
    input logic eoc_fall,
    input logic tx_busy
);
    AST_FERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err); // R4
    AST_FERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !adc_start_n) |=> !adc_start_n); // R4
    AST_START_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_start_n) |-> $past(rx_valid)); // R2
    AST_HOLD_UNTIL_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start_n && !eoc_fall) |=> adc_start_n); // R5
    AST_EOC_ENDS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start_n && eoc_fall) |=> !adc_start_n); // R5
    AST_REPLY_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_start_n) |-> tx_busy); // R5
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd); // R6
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        !(adc_start_n && tx_busy)); // R7
endmodule

bind adc_uart_bridge adcb_chk i_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .adc_start_n(adc_start_n),
    .frame_err(frame_err), .rx_valid(rx_valid), .eoc_fall(eoc_fall),
    .tx_busy(tx_busy)
);

// File: tb/test_adc_uart_bridge.sv
module test_adc_uart_bridge;
    localparam int BIT = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic adc_eoc_n = 1'b1;
    logic [7:0] adc_data = 8'h00;
    logic txd, adc_start_n, frame_err;

    int errs = 0;
    int checks = 0;
    int ferr_cnt = 0;
    int txlow_cnt = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    adc_uart_bridge #(.CLK_HZ(307200), .BAUD(9600), .OVS(16), .DW(8)) i_adc_uart_bridge (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd),
        .adc_start_n(adc_start_n), .adc_eoc_n(adc_eoc_n),
        .adc_data(adc_data), .frame_err(frame_err)
    );

    always @(posedge clk) begin
        if (frame_err) ferr_cnt <= ferr_cnt + 1;
        if (!txd)      txlow_cnt <= txlow_cnt + 1;
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit good_stop);
        rxd = 1'b0;
        wait_n(BIT);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_n(BIT);
        end
        if (good_stop) begin
            rxd = 1'b1;
            wait_n(BIT);
        end else begin
            rxd = 1'b0;
            wait_n(20);
            rxd = 1'b1;
            wait_n(BIT);
        end
    endtask

    task automatic capture(output logic [7:0] v, output bit framed);
        int n = 0;
        v = 8'h00;
        framed = 1'b0;
        while (txd && n < 300) begin
            @(negedge clk);
            n++;
        end
        if (!txd) begin
            wait_n(BIT / 2);
            framed = !txd;
            for (int i = 0; i < 8; i++) begin
                wait_n(BIT);
                v[i] = txd;
            end
            wait_n(BIT);
            framed = framed && txd;
        end
    endtask

    task automatic convert(input logic [7:0] val);
        logic [7:0] got;
        bit framed;
        adc_data  = val;
        adc_eoc_n = 1'b0;
        capture(got, framed);
        chk(framed, "R6 frame start/stop", framed, 1);
        chk(got == val, "R6 reply data", got, val);
        chk(!adc_start_n, "R5 start_n low after completion", adc_start_n, 0);
        adc_eoc_n = 1'b1;
        wait_n(BIT + 8);
    endtask

    initial begin
        logic [7:0] trig, val, got;
        bit framed;
        int base;

        wait_n(5);
        chk(txd == 1'b1, "R1 txd idle", txd, 1);
        chk(adc_start_n == 1'b0, "R1 start_n held", adc_start_n, 0);
        chk(frame_err == 1'b0, "R1 frame_err", frame_err, 0);
        rst_n = 1'b1;
        wait_n(5);
        chk(txd == 1'b1 && adc_start_n == 1'b0, "R1 after release", {txd, adc_start_n}, 2);

        // R2 R9 R5 R6 sweep of trigger and result values
        for (int i = 0; i < 40; i++) begin
            trig = 8'((i * 53 + 7) & 255);
            if (i < 8)       val = 8'(1 << i);
            else if (i < 16) val = ~8'(1 << (i - 8));
            else             val = 8'((i * 37 + 11) & 255);
            send_frame(trig, 1'b1);
            wait_n(4);
            chk(adc_start_n, "R2 R9 trigger starts conversion", adc_start_n, 1);
            convert(val);
        end

        // R3 short glitch
        rxd = 1'b0;
        wait_n(8);
        rxd = 1'b1;
        wait_n(400);
        chk(!adc_start_n, "R3 glitch rejected", adc_start_n, 0);

        // R4 bad stop bit
        base = ferr_cnt;
        send_frame(8'h5A, 1'b0);
        wait_n(100);
        chk(ferr_cnt - base == 1, "R4 one frame_err pulse", ferr_cnt - base, 1);
        chk(!adc_start_n, "R4 no conversion", adc_start_n, 0);

        // R8 stray completion edge
        base = txlow_cnt;
        adc_eoc_n = 1'b0;
        wait_n(400);
        chk(txlow_cnt == base, "R8 no reply without conversion", txlow_cnt - base, 0);

        // R10 completion line already low
        send_frame(8'h00, 1'b1);
        wait_n(4);
        chk(adc_start_n, "R10 conversion starts", adc_start_n, 1);
        wait_n(300);
        chk(adc_start_n && txlow_cnt == base, "R10 level low is not an edge",
            txlow_cnt - base, 0);
        adc_eoc_n = 1'b1;
        wait_n(10);
        convert(8'hA5);

        // R7 trigger during conversion
        send_frame(8'h11, 1'b1);
        send_frame(8'h22, 1'b1);
        wait_n(4);
        chk(adc_start_n, "R7 still one conversion", adc_start_n, 1);
        convert(8'h3C);
        wait_n(400);
        chk(!adc_start_n, "R7 second trigger dropped", adc_start_n, 0);

        // R7 trigger during reply
        send_frame(8'hFF, 1'b1);
        wait_n(4);
        adc_data  = 8'h96;
        adc_eoc_n = 1'b0;
        fork
            capture(got, framed);
            send_frame(8'h77, 1'b1);
        join
        chk(framed && got == 8'h96, "R7 reply intact", got, 8'h96);
        adc_eoc_n = 1'b1;
        wait_n(40);
        chk(!adc_start_n, "R7 trigger during reply dropped", adc_start_n, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule